// File: doc/BRIEF.md
# Page Programming Buffer and Sequencer

This block sits between the serial command front end of a non-volatile memory and its storage array. After the front end decodes a write instruction and its address, it opens a frame on this block. Each data byte that follows is placed in a one-page buffer. The slot for each byte comes from the low bits of the start address, and those bits advance after every byte. When the slot pointer runs past the last slot it wraps to the first slot of the same page. Any byte already in that slot is replaced. A mask records which slots have received data.

When the front end reports that chip select has gone high, the block decides whether to program. It programs only if three conditions hold at that point: the rise fell on a byte boundary, at least one byte was received, and the write-allowed qualifier is high. The write-allowed qualifier combines the write-enable latch with the protection result, which is computed outside this block. If programming goes ahead, the block scans the buffer in ascending slot order and issues one array write for each slot that was received. It then waits for a programmable number of clock cycles to model the self-timed cell programming. Busy stays high for the whole scan and wait. In its last cycle the block pulses a request that clears the write-enable latch. If any condition fails, the frame is dropped and nothing is written. While busy, the block ignores new frames, bytes and chip-select rises.

Top module: `page_prog_seq`

## Requirements
- R1: After synchronous reset, busy, arr_we and wel_clr are all low.
- R2: The first byte of a frame goes to the slot given by the low log2(PAGE_BYTES) bits of start_addr. Each later byte goes to the next slot, and the slot index wraps from PAGE_BYTES-1 to 0.
- R3: When a frame carries more than PAGE_BYTES bytes, a later byte replaces an earlier byte in the same slot. Only the latest value of each slot is programmed.
- R4: A commit issues exactly one array write for each received slot and none for any other slot. The writes are issued in ascending slot order. The upper address bits equal the page bits of start_addr, and arr_we is only ever high while busy.
- R5: A commit happens only if cs_rise comes with cs_aligned=1 and wr_allowed=1, after at least one byte has been received. Otherwise the frame is dropped, with no writes and no busy.
- R6: Busy rises in the cycle after the accepted cs_rise and stays high for exactly PAGE_BYTES + PROG_CYCLES cycles.
- R7: wel_clr is a single-cycle pulse in the last busy cycle. There is exactly one pulse per commit and none for a dropped frame.
- R8: While busy, frame_start, byte_vld and cs_rise have no effect on the writes, on the busy length, or on what happens after busy ends.
- R9: Outside an open frame, byte_vld and cs_rise are ignored. After a dropped frame, a new frame_start is needed before anything can be programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Opens a write frame; start_addr is sampled |
| start_addr | input | ADDR_W | First byte address of the frame |
| byte_vld | input | 1 | One complete data byte is present |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select has gone high |
| cs_aligned | input | 1 | With cs_rise: the rise fell on a byte boundary |
| wr_allowed | input | 1 | Write-enable latch set and target not protected |
| arr_we | output | 1 | Array write request |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | Pulse requesting that the write-enable latch clear |

## Verification
The assertions assume well-formed front-end strobes: cs_rise and byte_vld are never high in the same cycle, and all inputs are known once reset is released. The bench meets this by driving each strobe as a separate single-cycle pulse on the falling clock edge. It also keeps the strobes separate when it injects stray traffic during busy. The bench uses an 8-byte page and a 5-cycle programming time, so every start slot can be combined with every frame length, including lengths that wrap once.

// File: rtl/page_prog_pkg.sv
// Package: shared state encoding for the page programming sequencer.
package page_prog_pkg;
    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,  // no frame open
        PS_COLLECT = 2'd1,  // frame open, gathering bytes
        PS_SCAN    = 2'd2,  // walking the buffer, issuing array writes
        PS_WAIT    = 2'd3   // self-timed programming delay
    } pps_state_t;
endpackage

// File: rtl/page_prog_buffer.sv
// Module: one-page byte buffer with a per-slot valid mask.
// Purpose: stores bytes at a wrapping slot pointer and exposes one slot
// per cycle for readout.
// Assumes: PAGE_BYTES is a power of two, and clear and wr are never high
// together (the sequencer orders them).
module page_prog_buffer #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [OFF_W-1:0]  load_off,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic [OFF_W-1:0]      ptr_q;

    // Mask and pointer: cleared on a new frame, advanced on each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ptr_q  <= '0;
        end else if (clear) begin
            mask_q <= '0;
            ptr_q  <= load_off;
        end else if (wr) begin
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + 1'b1;
        end
    end

    // Data slots: hold no reset, because the mask gates every use.
    always_ff @(posedge clk) begin
        if (wr && !clear) slot_q[ptr_q] <= wdata;
    end

    // Readout of the slot selected by the scan index.
    always_comb begin
        rd_data = slot_q[rd_idx];
        rd_vld  = mask_q[rd_idx];
        any_vld = |mask_q;
    end
endmodule

// File: rtl/page_prog_timer.sv
// Module: self-timed programming delay counter.
// Purpose: counts while run is high and flags the final cycle of a
// CYCLES-long window.
// Assumes: CYCLES >= 1, and run stays high until last has been seen.
module page_prog_timer #(
    parameter int CYCLES  = 500000,
    localparam int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    logic [CNT_W-1:0] cnt_q;

    // Counter: held at zero while idle and advanced while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // Final-cycle flag.
    always_comb last = run && (cnt_q == CNT_W'(CYCLES - 1));
endmodule

// File: rtl/page_prog_seq.sv
// Module: page write buffer and programming sequencer (top).
// Purpose: gathers one frame of bytes and, on a valid chip-select rise,
// commits the received slots to the array and then holds busy for the
// programming time.
// Assumes: the front end never raises cs_rise and byte_vld in the same
// cycle, and it computes wr_allowed from the write-enable latch and the
// protection settings.
module page_prog_seq
    import page_prog_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BYTES  = 128,
    parameter int PROG_CYCLES = 500000,
    localparam int DATA_W     = 8,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    input  logic              wr_allowed,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    output logic              busy,
    output logic              wel_clr
);
    pps_state_t        state_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  scan_q;
    logic              buf_clear;
    logic              buf_wr;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld;
    logic              any_vld;
    logic              tmr_last;
    logic              commit_ok;

    // Frame-level decodes: open a frame, accept a byte, qualify a commit.
    always_comb begin
        buf_clear = frame_start && !cs_rise &&
                    (state_q == PS_IDLE || state_q == PS_COLLECT);
        buf_wr    = byte_vld && !cs_rise && !frame_start &&
                    (state_q == PS_COLLECT);
        commit_ok = cs_aligned && wr_allowed && any_vld;
    end

    page_prog_buffer #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (buf_clear),
        .load_off (start_addr[OFF_W-1:0]),
        .wr       (buf_wr),
        .wdata    (byte_data),
        .rd_idx   (scan_q),
        .rd_data  (rd_data),
        .rd_vld   (rd_vld),
        .any_vld  (any_vld)
    );

    page_prog_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == PS_WAIT),
        .last  (tmr_last)
    );

    // Sequencer: frame collection, scan of the mask, then the timed wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            page_q  <= '0;
            scan_q  <= '0;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    if (buf_clear) begin
                        state_q <= PS_COLLECT;
                        page_q  <= start_addr[ADDR_W-1:OFF_W];
                    end
                end
                PS_COLLECT: begin
                    if (cs_rise) begin
                        state_q <= commit_ok ? PS_SCAN : PS_IDLE;
                        scan_q  <= '0;
                    end else if (buf_clear) begin
                        page_q  <= start_addr[ADDR_W-1:OFF_W];
                    end
                end
                PS_SCAN: begin
                    scan_q <= scan_q + 1'b1;
                    if (scan_q == OFF_W'(PAGE_BYTES - 1)) state_q <= PS_WAIT;
                end
                PS_WAIT: begin
                    if (tmr_last) state_q <= PS_IDLE;
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    // Outputs: array write port, busy flag and write-enable clear request.
    always_comb begin
        busy     = (state_q == PS_SCAN) || (state_q == PS_WAIT);
        arr_we   = (state_q == PS_SCAN) && rd_vld;
        arr_addr = {page_q, scan_q};
        arr_data = rd_data;
        wel_clr  = tmr_last;
    end
endmodule

// File: rtl/page_prog_seq_chk.sv
// Module: protocol checker bound to page_prog_seq.
// Purpose: watches the port-level ordering of commit, busy, array writes
// and the write-enable clear request.
// Assumes: inputs are known after reset.
module page_prog_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_rise,
    input logic cs_aligned,
    input logic wr_allowed,
    input logic arr_we,
    input logic busy,
    input logic wel_clr
);
    // R4: array writes only happen inside a programming cycle.
    assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R5: busy can start only after a qualified chip-select rise.
    assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && cs_aligned && wr_allowed));

    // R6: busy is held until the final cycle.
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wel_clr) |=> busy);

    // R7: the clear pulse ends the cycle.
    assert_wel_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !busy);

    // R7: busy only falls right after a clear pulse.
    assert_fall_after_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wel_clr));

    // R7: the clear pulse never appears outside a cycle.
    assert_wel_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> busy);
endmodule

bind page_prog_seq page_prog_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise    (cs_rise),
    .cs_aligned (cs_aligned),
    .wr_allowed (wr_allowed),
    .arr_we     (arr_we),
    .busy       (busy),
    .wel_clr    (wel_clr)
);

// File: tb/page_prog_seq_tb.sv
// Bench: sweeps every start slot against frame lengths 0..12 on an 8-byte
// page, plus the drop conditions and stray traffic while busy.
module page_prog_seq_tb;
    localparam int AW = 8;
    localparam int PG = 8;
    localparam int PC = 5;
    localparam int BUSY_LEN = PG + PC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic cs_rise = 1'b0;
    logic cs_aligned = 1'b0;
    logic wr_allowed = 1'b0;
    logic arr_we;
    logic [AW-1:0] arr_addr;
    logic [7:0] arr_data;
    logic busy;
    logic wel_clr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] mem [256];
    int wcnt [256];
    int total_w = 0;
    int wel_cnt = 0;
    int order_err = 0;
    int prev_off = -1;

    page_prog_seq #(.ADDR_W(AW), .PAGE_BYTES(PG), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .start_addr(start_addr), .byte_vld(byte_vld), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_aligned(cs_aligned), .wr_allowed(wr_allowed),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
        .busy(busy), .wel_clr(wel_clr)
    );

    always #2.5 clk = ~clk;

    // Array model and write monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (arr_we) begin
            mem[arr_addr] <= arr_data;
            wcnt[arr_addr] = wcnt[arr_addr] + 1;
            total_w = total_w + 1;
            if (int'(arr_addr % PG) <= prev_off) order_err = order_err + 1;
            prev_off = int'(arr_addr % PG);
        end
        if (!busy) prev_off = -1;
        if (wel_clr) wel_cnt = wel_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dval(input int pg, input int off, input int i);
        return 8'((pg * 7 + off * 13 + i * 29 + 1) & 255);
    endfunction

    task automatic clear_log();
        @(negedge clk);
        for (int a = 0; a < 256; a++) wcnt[a] = 0;
        total_w = 0;
        wel_cnt = 0;
        order_err = 0;
    endtask

    // One frame: open, n bytes, chip-select rise, then watch busy.
    task automatic run_case(input int pg, input int off, input int n,
                            input bit aligned, input bit allowed, input bit inject);
        logic [7:0] exp_d [PG];
        bit exp_v [PG];
        bit commit;
        int busy_len = 0;
        int bad = 0;
        int nvalid = 0;
        string tag;
        clear_log();
        for (int s = 0; s < PG; s++) begin exp_v[s] = 0; exp_d[s] = '0; end
        start_addr  = AW'(pg * PG + off);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld  = 1'b1;
            byte_data = dval(pg, off, i);
            exp_d[(off + i) % PG] = dval(pg, off, i);
            exp_v[(off + i) % PG] = 1;
            @(negedge clk);
        end
        byte_vld   = 1'b0;
        cs_rise    = 1'b1;
        cs_aligned = aligned;
        wr_allowed = allowed;
        commit = aligned && allowed && (n > 0);
        for (int k = 0; k < BUSY_LEN + 12; k++) begin
            @(negedge clk);
            if (busy) busy_len++;
            cs_rise     = inject && (k == 3);
            cs_aligned  = inject && (k == 3);
            wr_allowed  = inject && (k == 3);
            frame_start = inject && (k == 1);
            start_addr  = inject && (k == 1) ? AW'(((pg + 1) % 32) * PG) : start_addr;
            byte_vld    = inject && (k == 2);
            byte_data   = 8'hA5;
        end
        frame_start = 1'b0; byte_vld = 1'b0; cs_rise = 1'b0;
        cs_aligned = 1'b0; wr_allowed = 1'b0;
        for (int s = 0; s < PG; s++) begin
            int a;
            a = pg * PG + s;
            if (exp_v[s] && commit) begin
                nvalid++;
                if (wcnt[a] != 1 || mem[a] != exp_d[s]) bad++;
            end else if (wcnt[a] != 0) bad++;
        end
        tag = inject ? "R8" : "";
        check(commit ? "R6 busy length" : "R5 no busy on drop", busy_len, commit ? BUSY_LEN : 0);
        check("R7 clear pulses", wel_cnt, commit ? 1 : 0);
        check(n > PG ? "R3 slot contents" : "R2 slot contents", bad, 0);
        check("R4 write count", total_w, nvalid);
        check("R4 ascending order", order_err, 0);
        if (inject) check("R8 stray traffic during busy", total_w + bad, nvalid);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) begin mem[a] = '0; wcnt[a] = 0; end
        repeat (3) @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 arr_we after reset", int'(arr_we), 0);
        check("R1 wel_clr after reset", int'(wel_clr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", int'(busy || arr_we || wel_clr), 0);

        // Sweep: every start slot, every length 0..12 (includes wrap).
        for (int off = 0; off < PG; off++)
            for (int n = 0; n <= PG + 4; n++)
                run_case((off * 5 + n) % 32, off, n, 1'b1, 1'b1, 1'b0);

        // R5: misaligned rise and missing write permission drop the frame.
        for (int n = 1; n <= 3; n++) begin
            run_case(3, n, n, 1'b0, 1'b1, 1'b0);
            run_case(4, n, n, 1'b1, 1'b0, 1'b0);
        end

        // R8: strobes during busy have no effect.
        run_case(9, 6, 4, 1'b1, 1'b1, 1'b1);
        run_case(10, 0, 10, 1'b1, 1'b1, 1'b1);

        // R9: bytes and a rise with no open frame, right after a drop.
        run_case(11, 2, 2, 1'b0, 1'b1, 1'b0);
        clear_log();
        byte_vld = 1'b1; byte_data = 8'h3C; @(negedge clk);
        byte_vld = 1'b0; cs_rise = 1'b1; cs_aligned = 1'b1; wr_allowed = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0; cs_aligned = 1'b0; wr_allowed = 1'b0;
        repeat (BUSY_LEN + 4) begin
            @(negedge clk);
            if (busy) total_w = total_w + 1000;
        end
        check("R9 no commit without frame", total_w, 0);
        check("R9 no clear pulse without frame", wel_cnt, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule